// File: doc/BRIEF.md
# Qualified Threshold Alarm Engine

This block watches one telemetry quantity, such as a module temperature or a received optical power, and turns its samples into a stable alarm severity. Each sample comes with a valid strobe. A free-running millisecond tick measures time. A configuration bit sets the polarity. On the high side, a reading at or above a limit is a crossing. On the low side, a reading at or below a limit is a crossing.

The block has four states: NORMAL, WARNING, ALARM and LATCHED.

- Entry. A crossing must persist for a programmed number of ticks before the state rises. Entry needs sustained time, not a count of samples.
- Exit. Leaving a state uses a separate pair of exit limits, which gives hysteresis. The value must stay inside the exit limit for its own hold time.
- Latching. When latching is enabled, critical alarms latch. They are released by a manual clear pulse or, if selected, by an automatic cool-down.

Each state change produces a one-cycle notification that carries the new severity. Masking or a per-window cap on notifications can suppress it. Suppressed changes are still counted, along with warning and alarm entries.

Top module: `qual_alarm_engine`

Named transitions:
- NORMAL->WARNING (warn qualify)
- NORMAL->ALARM or NORMAL->LATCHED, and WARNING->ALARM or WARNING->LATCHED (alarm qualify)
- ALARM->WARNING or ALARM->NORMAL (alarm exit)
- WARNING->NORMAL (warn exit)
- LATCHED->NORMAL (manual clear)
- LATCHED->WARNING or LATCHED->NORMAL (cool-down release)

## Requirements
- R1: After reset, severity is 0 (NORMAL), latched and notify are 0, and all three counters are 0.
- R2: A state rises to WARNING or ALARM only after its enter limit has been crossed at every accepted sample for t_warn or t_alarm tick pulses. The tick count restarts at zero whenever an accepted sample stops crossing, and it restarts on every state change.
- R3: If both qualifications complete in the same cycle, the alarm qualification wins. A rise from NORMAL can therefore go directly to ALARM.
- R4: ALARM is left only after the value has stayed inside the alarm exit limit for t_clear ticks. The next state is NORMAL if the value is also inside the warning exit limit, and WARNING otherwise. WARNING returns to NORMAL after the value has stayed inside the warning exit limit for t_clear ticks.
- R5: With cfg_latch set, a qualified alarm enters LATCHED (severity 3, latched=1). LATCHED stays in place until a clear_req pulse, which moves it to NORMAL on the next clock edge.
- R6: With cfg_auto_clear set, LATCHED is released once the value has stayed inside the alarm exit limit for t_cool ticks. The release goes to NORMAL or WARNING using the same rule as R4. With cfg_auto_clear clear, no amount of time in range releases it.
- R7: While warmup is high, samples are accepted but no qualification progresses, so the severity never rises. Qualification time starts from zero once warmup falls.
- R8: While mask is high, state changes and counters behave as usual, but notify stays low and each change increments cnt_drop.
- R9: No more than rl_max notifications are sent per window of rl_window ticks. Each excess change increments cnt_drop, and a new window allows notifications again.
- R10: Every state change produces either a one-cycle notify in the same cycle the severity changes, or a cnt_drop increment. notify_sev carries the new severity (0 normal, 1 warning, 2 alarm, 3 latched). cnt_warn counts NORMAL->WARNING changes. cnt_alarm counts entries into ALARM or LATCHED from NORMAL or WARNING.
- R11: Samples with sample_valid low have no effect. Qualification, exit and cool-down times advance only on tick pulses.
- R12: With cfg_high_side=1, crossing means value >= the enter limit, and inside-exit means value < the exit limit. With cfg_high_side=0, crossing means value <= the enter limit, and inside-exit means value > the exit limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Qualifies sample_value this cycle |
| sample_value | input | VAL_W | Monitored telemetry reading |
| tick | input | 1 | One-cycle millisecond time pulse |
| warmup | input | 1 | Holds qualification at zero |
| cfg_high_side | input | 1 | 1 = high-side signal, 0 = low-side |
| lim_warn_in | input | VAL_W | Warning enter limit |
| lim_alarm_in | input | VAL_W | Alarm enter limit |
| lim_warn_out | input | VAL_W | Warning exit (hysteresis) limit |
| lim_alarm_out | input | VAL_W | Alarm exit (hysteresis) limit |
| t_warn | input | TIME_W | Warning qualify time in ticks |
| t_alarm | input | TIME_W | Alarm qualify time in ticks |
| t_clear | input | TIME_W | Exit hold time in ticks |
| t_cool | input | TIME_W | Latched cool-down time in ticks |
| cfg_latch | input | 1 | Qualified alarms go to LATCHED |
| cfg_auto_clear | input | 1 | Enables cool-down release of LATCHED |
| clear_req | input | 1 | Manual clear pulse for LATCHED |
| mask | input | 1 | Suppresses notifications |
| rl_window | input | TIME_W | Rate window length in ticks |
| rl_max | input | RL_W | Notifications allowed per window |
| severity | output | 2 | Current state as severity code |
| latched | output | 1 | High in LATCHED |
| notify | output | 1 | One-cycle change notification |
| notify_sev | output | 2 | Severity carried by notify |
| cnt_warn | output | CNT_W | Warning entries |
| cnt_alarm | output | CNT_W | Alarm entries |
| cnt_drop | output | CNT_W | Suppressed notifications |

## Verification
A wrong state register or a wrong transition shows on severity in the cycle right after the qualifying tick or sample. It also shows as an unexpected or missing notify in that same cycle, which the notification scoreboard catches. A qualify or exit timer that fails to restart, or that counts without ticks, moves the severity one or more ticks early or late. The bench samples the severity one tick before and exactly at each expected expiry. Drift in the rate window or the mask path shows up in the notification sequence and in cnt_drop right away.

// File: rtl/qual_alarm_pkg.sv
package qual_alarm_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_WARNING = 2'd1,
        ST_ALARM   = 2'd2,
        ST_LATCHED = 2'd3
    } alm_state_t;

endpackage

// File: rtl/qual_alarm_cmp.sv
module qual_alarm_cmp #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [VAL_W-1:0] sample_value,
    input  logic             high_side,
    input  logic [VAL_W-1:0] lim_warn_in,
    input  logic [VAL_W-1:0] lim_alarm_in,
    input  logic [VAL_W-1:0] lim_warn_out,
    input  logic [VAL_W-1:0] lim_alarm_out,
    output logic             over_warn,
    output logic             over_alarm,
    output logic             inside_warn,
    output logic             inside_alarm
);

    localparam int NLIM = 4;

    logic [VAL_W-1:0] lims [NLIM];
    logic [NLIM-1:0]  hit;

    assign lims[0] = lim_warn_in;
    assign lims[1] = lim_alarm_in;
    assign lims[2] = lim_warn_out;
    assign lims[3] = lim_alarm_out;

    // enter limits (0,1) use an inclusive crossing, exit limits (2,3) a strict inside test
    for (genvar g = 0; g < NLIM; g++) begin : g_cmp
        if (g < 2) begin : g_enter
            assign hit[g] = high_side ? (sample_value >= lims[g]) : (sample_value <= lims[g]);
        end else begin : g_exit
            assign hit[g] = high_side ? (sample_value < lims[g]) : (sample_value > lims[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            over_warn    <= 1'b0;
            over_alarm   <= 1'b0;
            inside_warn  <= 1'b0;
            inside_alarm <= 1'b0;
        end else if (sample_valid) begin
            over_warn    <= hit[0];
            over_alarm   <= hit[1];
            inside_warn  <= hit[2];
            inside_alarm <= hit[3];
        end
    end

endmodule

// File: rtl/qual_alarm_timer.sv
module qual_alarm_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              cond,
    input  logic              tick,
    input  logic [TIME_W-1:0] limit,
    output logic              done
);

    localparam logic [TIME_W-1:0] CNT_MAX = '1;

    logic [TIME_W-1:0] cnt_q;

    assign done = cond && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !cond) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r11_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > $past(cnt_q)) |-> $past(tick));

endmodule

// File: rtl/qual_alarm_notify.sv
module qual_alarm_notify #(
    parameter int TIME_W = 16,
    parameter int RL_W   = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [TIME_W-1:0] rl_window,
    input  logic [RL_W-1:0]   rl_max,
    input  logic              mask,
    input  logic              change,
    input  logic [1:0]        new_sev,
    input  logic              enter_warn,
    input  logic              enter_alarm,
    output logic              notify,
    output logic [1:0]        notify_sev,
    output logic [CNT_W-1:0]  cnt_warn,
    output logic [CNT_W-1:0]  cnt_alarm,
    output logic [CNT_W-1:0]  cnt_drop
);

    logic [TIME_W-1:0] win_q;
    logic [RL_W-1:0]   sent_q;
    logic              roll;
    logic              allowed;

    assign roll    = tick && ({1'b0, win_q} + 1'b1 >= {1'b0, rl_window});
    assign allowed = !mask && (roll ? (rl_max != '0) : (sent_q < rl_max));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (roll) begin
            win_q <= '0;
        end else if (tick) begin
            win_q <= win_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= '0;
        end else if (roll) begin
            sent_q <= (change && allowed) ? RL_W'(1) : '0;
        end else if (change && allowed) begin
            sent_q <= sent_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify     <= 1'b0;
            notify_sev <= 2'd0;
            cnt_warn   <= '0;
            cnt_alarm  <= '0;
            cnt_drop   <= '0;
        end else begin
            notify <= change && allowed;
            if (change) begin
                notify_sev <= new_sev;
            end
            if (change && !allowed) begin
                cnt_drop <= cnt_drop + 1'b1;
            end
            if (enter_warn) begin
                cnt_warn <= cnt_warn + 1'b1;
            end
            if (enter_alarm) begin
                cnt_alarm <= cnt_alarm + 1'b1;
            end
        end
    end

    a_r8_mask_silent: assert property (@(posedge clk) disable iff (!rst_n)
        mask |=> !notify);

    a_r9_cap_per_window: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sent_q) == 32'($past(sent_q)) + 1) |-> ($past(sent_q) < $past(rl_max)));

endmodule

// File: rtl/qual_alarm_engine.sv
module qual_alarm_engine
    import qual_alarm_pkg::*;
#(
    parameter int VAL_W  = 16,
    parameter int TIME_W = 16,
    parameter int RL_W   = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [VAL_W-1:0]  sample_value,
    input  logic              tick,
    input  logic              warmup,
    input  logic              cfg_high_side,
    input  logic [VAL_W-1:0]  lim_warn_in,
    input  logic [VAL_W-1:0]  lim_alarm_in,
    input  logic [VAL_W-1:0]  lim_warn_out,
    input  logic [VAL_W-1:0]  lim_alarm_out,
    input  logic [TIME_W-1:0] t_warn,
    input  logic [TIME_W-1:0] t_alarm,
    input  logic [TIME_W-1:0] t_clear,
    input  logic [TIME_W-1:0] t_cool,
    input  logic              cfg_latch,
    input  logic              cfg_auto_clear,
    input  logic              clear_req,
    input  logic              mask,
    input  logic [TIME_W-1:0] rl_window,
    input  logic [RL_W-1:0]   rl_max,
    output logic [1:0]        severity,
    output logic              latched,
    output logic              notify,
    output logic [1:0]        notify_sev,
    output logic [CNT_W-1:0]  cnt_warn,
    output logic [CNT_W-1:0]  cnt_alarm,
    output logic [CNT_W-1:0]  cnt_drop
);

    alm_state_t state_q, state_d;

    logic over_warn, over_alarm, inside_warn, inside_alarm;
    logic chg;
    logic w_done, a_done, x_done;
    logic x_cond;
    logic [TIME_W-1:0] x_limit;
    logic enter_warn, enter_alarm;

    qual_alarm_cmp #(.VAL_W(VAL_W)) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_value (sample_value),
        .high_side    (cfg_high_side),
        .lim_warn_in  (lim_warn_in),
        .lim_alarm_in (lim_alarm_in),
        .lim_warn_out (lim_warn_out),
        .lim_alarm_out(lim_alarm_out),
        .over_warn    (over_warn),
        .over_alarm   (over_alarm),
        .inside_warn  (inside_warn),
        .inside_alarm (inside_alarm)
    );

    qual_alarm_timer #(.TIME_W(TIME_W)) u_wq (
        .clk(clk), .rst_n(rst_n), .restart(chg),
        .cond(over_warn && !warmup), .tick(tick), .limit(t_warn), .done(w_done)
    );

    qual_alarm_timer #(.TIME_W(TIME_W)) u_aq (
        .clk(clk), .rst_n(rst_n), .restart(chg),
        .cond(over_alarm && !warmup), .tick(tick), .limit(t_alarm), .done(a_done)
    );

    always_comb begin
        unique case (state_q)
            ST_NORMAL:  x_cond = 1'b0;
            ST_WARNING: x_cond = inside_warn;
            ST_ALARM:   x_cond = inside_alarm;
            ST_LATCHED: x_cond = inside_alarm;
        endcase
    end

    assign x_limit = (state_q == ST_LATCHED) ? t_cool : t_clear;

    qual_alarm_timer #(.TIME_W(TIME_W)) u_exit (
        .clk(clk), .rst_n(rst_n), .restart(chg),
        .cond(x_cond), .tick(tick), .limit(x_limit), .done(x_done)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (a_done)      state_d = cfg_latch ? ST_LATCHED : ST_ALARM;
                else if (w_done) state_d = ST_WARNING;
            end
            ST_WARNING: begin
                if (a_done)      state_d = cfg_latch ? ST_LATCHED : ST_ALARM;
                else if (x_done) state_d = ST_NORMAL;
            end
            ST_ALARM: begin
                if (x_done)      state_d = inside_warn ? ST_NORMAL : ST_WARNING;
            end
            ST_LATCHED: begin
                if (clear_req)                    state_d = ST_NORMAL;
                else if (cfg_auto_clear && x_done) state_d = inside_warn ? ST_NORMAL : ST_WARNING;
            end
        endcase
    end

    assign chg         = (state_d != state_q);
    assign enter_warn  = (state_q == ST_NORMAL) && (state_d == ST_WARNING);
    assign enter_alarm = ((state_q == ST_NORMAL) || (state_q == ST_WARNING)) &&
                         ((state_d == ST_ALARM) || (state_d == ST_LATCHED));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        severity = 2'(state_q);
        latched  = (state_q == ST_LATCHED);
    end

    qual_alarm_notify #(.TIME_W(TIME_W), .RL_W(RL_W), .CNT_W(CNT_W)) u_ntf (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rl_window  (rl_window),
        .rl_max     (rl_max),
        .mask       (mask),
        .change     (chg),
        .new_sev    (2'(state_d)),
        .enter_warn (enter_warn),
        .enter_alarm(enter_alarm),
        .notify     (notify),
        .notify_sev (notify_sev),
        .cnt_warn   (cnt_warn),
        .cnt_alarm  (cnt_alarm),
        .cnt_drop   (cnt_drop)
    );

    a_r10_notify_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> (severity != $past(severity)));

    a_r7_warmup_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $past(warmup) |-> !(severity > $past(severity)));

    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && !clear_req && !cfg_auto_clear) |=> (state_q == ST_LATCHED));

endmodule

// File: tb/qual_alarm_engine_test.sv
module qual_alarm_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_value = '0;
    logic        tick = 1'b0;
    logic        warmup = 1'b0;
    logic        cfg_high_side = 1'b1;
    logic [15:0] lim_warn_in = 16'd100;
    logic [15:0] lim_alarm_in = 16'd200;
    logic [15:0] lim_warn_out = 16'd90;
    logic [15:0] lim_alarm_out = 16'd180;
    logic [15:0] t_warn = 16'd3;
    logic [15:0] t_alarm = 16'd4;
    logic [15:0] t_clear = 16'd2;
    logic [15:0] t_cool = 16'd5;
    logic        cfg_latch = 1'b0;
    logic        cfg_auto_clear = 1'b0;
    logic        clear_req = 1'b0;
    logic        mask = 1'b0;
    logic [15:0] rl_window = 16'd60000;
    logic [7:0]  rl_max = 8'd100;
    logic [1:0]  severity;
    logic        latched;
    logic        notify;
    logic [1:0]  notify_sev;
    logic [15:0] cnt_warn, cnt_alarm, cnt_drop;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int exp_warn = 0, exp_alarm = 0, exp_drop = 0, prev_sev = 0;
    int sb_q[$];

    always #4 clk = ~clk;

    qual_alarm_engine uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_value(sample_value),
        .tick(tick), .warmup(warmup), .cfg_high_side(cfg_high_side),
        .lim_warn_in(lim_warn_in), .lim_alarm_in(lim_alarm_in),
        .lim_warn_out(lim_warn_out), .lim_alarm_out(lim_alarm_out),
        .t_warn(t_warn), .t_alarm(t_alarm), .t_clear(t_clear), .t_cool(t_cool),
        .cfg_latch(cfg_latch), .cfg_auto_clear(cfg_auto_clear), .clear_req(clear_req),
        .mask(mask), .rl_window(rl_window), .rl_max(rl_max),
        .severity(severity), .latched(latched), .notify(notify), .notify_sev(notify_sev),
        .cnt_warn(cnt_warn), .cnt_alarm(cnt_alarm), .cnt_drop(cnt_drop)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver side of the scoreboard: predicted state change and whether it notifies
    task automatic exp_tr(input int new_sev, input bit sent);
        if (prev_sev == 0 && new_sev == 1) exp_warn++;
        if (prev_sev < 2 && new_sev >= 2) exp_alarm++;
        if (sent) sb_q.push_back(new_sev);
        else      exp_drop++;
        prev_sev = new_sev;
    endtask

    task automatic send(input int v);
        sample_value = 16'(v);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && notify) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected notify actual=%0d expected=none", notify_sev);
            end else begin
                int e;
                e = sb_q.pop_front();
                if (int'(notify_sev) != e) begin
                    errors++;
                    $display("FAIL R10 notify_sev actual=%0d expected=%0d", notify_sev, e);
                end
            end
        end
    end

    task automatic chk_counts(input string req);
        chk({req, " cnt_warn"}, cnt_warn, exp_warn);
        chk({req, " cnt_alarm"}, cnt_alarm, exp_alarm);
        chk({req, " cnt_drop"}, cnt_drop, exp_drop);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        // R1 reset state
        chk("R1 severity", severity, 0);
        chk("R1 latched", latched, 0);
        chk("R1 notify", notify, 0);
        chk_counts("R1");
        rst_n = 1'b1;
        idle(2);

        // R2 warning qualification by time
        send(150);
        ticks(2);
        chk("R2 warn not yet", severity, 0);
        exp_tr(1, 1);
        ticks(1);
        chk("R2 warn qualified", severity, 1);

        // R2 alarm qualify restarts when the crossing drops
        send(250);
        ticks(3);
        send(150);
        send(250);
        ticks(3);
        chk("R2 alarm timer restarted", severity, 1);
        exp_tr(2, 1);
        ticks(1);
        chk("R2 alarm qualified", severity, 2);

        // R4 hysteresis exit
        send(190);
        ticks(5);
        chk("R4 between limits holds alarm", severity, 2);
        send(150);
        exp_tr(1, 1);
        ticks(2);
        chk("R4 alarm exit to warning", severity, 1);
        send(95);
        ticks(4);
        chk("R4 warning holds above exit", severity, 1);
        send(50);
        ticks(1);
        chk("R4 warn exit not yet", severity, 1);
        exp_tr(0, 1);
        ticks(1);
        chk("R4 warning exit", severity, 0);

        // R7 warm-up gate
        warmup = 1'b1;
        send(250);
        ticks(10);
        chk("R7 no qualify in warmup", severity, 0);
        warmup = 1'b0;
        exp_tr(1, 1);
        ticks(3);
        chk("R7 qualify restarts after warmup", severity, 1);
        exp_tr(2, 1);
        ticks(4);
        chk("R7 alarm after warmup", severity, 2);
        send(50);
        exp_tr(0, 1);
        ticks(2);
        chk("R4 alarm exit straight to normal", severity, 0);
        chk_counts("R10");

        // R5 latching with manual clear
        cfg_latch = 1'b1;
        send(250);
        exp_tr(1, 1);
        ticks(3);
        exp_tr(3, 1);
        ticks(4);
        chk("R5 latched severity", severity, 3);
        chk("R5 latched flag", latched, 1);
        send(50);
        ticks(20);
        chk("R6 no auto release when disabled", severity, 3);
        exp_tr(0, 1);
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        chk("R5 manual clear", severity, 0);
        chk("R5 latched flag cleared", latched, 0);

        // R6 cool-down release
        cfg_auto_clear = 1'b1;
        send(250);
        exp_tr(1, 1);
        ticks(3);
        exp_tr(3, 1);
        ticks(4);
        chk("R6 latched again", severity, 3);
        send(50);
        ticks(4);
        chk("R6 cool-down not yet", severity, 3);
        exp_tr(0, 1);
        ticks(1);
        chk("R6 cool-down release", severity, 0);
        cfg_latch = 1'b0;
        cfg_auto_clear = 1'b0;

        // R8 mask: state and counters move, notify silent
        mask = 1'b1;
        send(250);
        exp_tr(1, 0);
        ticks(3);
        chk("R8 masked warning state", severity, 1);
        exp_tr(2, 0);
        ticks(4);
        chk("R8 masked alarm state", severity, 2);
        send(50);
        exp_tr(0, 0);
        ticks(2);
        chk("R8 masked back to normal", severity, 0);
        chk_counts("R8");
        mask = 1'b0;

        // R9 rate cap with immediate qualification
        rl_window = 16'd1;
        ticks(1);
        rl_window = 16'd100;
        rl_max = 8'd2;
        t_warn = 16'd0;
        t_alarm = 16'd0;
        t_clear = 16'd0;
        exp_tr(1, 1); send(150); idle(1);
        exp_tr(0, 1); send(50);  idle(1);
        exp_tr(1, 0); send(150); idle(1);
        chk("R9 capped change still moves state", severity, 1);
        exp_tr(0, 0); send(50);  idle(1);
        chk_counts("R9");
        ticks(100);
        exp_tr(1, 1); send(150); idle(1);
        chk("R9 new window notifies", severity, 1);
        rl_max = 8'd100;

        // R12 low-side polarity, R3 alarm priority
        cfg_high_side = 1'b0;
        lim_warn_in = 16'd50;
        lim_alarm_in = 16'd20;
        lim_warn_out = 16'd60;
        lim_alarm_out = 16'd30;
        exp_tr(0, 1); send(150); idle(1);
        chk("R12 low side inside exit", severity, 0);
        exp_tr(2, 1); send(10);  idle(1);
        chk("R3 alarm wins from normal", severity, 2);
        exp_tr(1, 1); send(40);  idle(1);
        chk("R12 low side alarm exit to warning", severity, 1);
        send(55); idle(2);
        chk("R12 low side between limits holds", severity, 1);
        exp_tr(0, 1); send(70);  idle(1);
        chk("R12 low side back to normal", severity, 0);

        // R11 invalid samples ignored
        sample_value = 16'd5;
        sample_valid = 1'b0;
        ticks(10);
        chk("R11 invalid sample ignored", severity, 0);
        chk_counts("R11");
        idle(2);
        chk("R10 all expected notifies seen", sb_q.size(), 0);
        finish_run();
    end

endmodule